// File: doc/BRIEF.md
# Streaming 2x2 Max-Pool Row Buffer

This block takes one channel of convolution results as a serial, valid-tagged stream in row-major order. It produces the 2x2, stride-2 maximum pool of that image as a second valid-tagged stream, ready to feed the next layer's window generator. The frame size is set by two parameters, and both must be even. Multi-channel traffic is served by instantiating the block once per channel, or by time-multiplexing it outside the block.

The block never assembles a 2x2 window. A single storage row holds one entry per pooled column, indexed by input column divided by two. Within a row pair, a pooled column receives four samples:

- The even-column sample of the upper row overwrites the entry.
- The other three samples each replace the entry with the signed maximum of the entry and the new sample.
- The fourth sample, which is the odd column of the lower row, also emits the result.

No output appears during upper rows, so each pooled row waits for two input rows.

A frame-start flag returns the position tracking to the first pixel. A sample presented together with that flag is taken as row 0, column 0. Without the flag, the position wraps to the origin on its own after the last pixel of a frame.

Top module: `maxpool2x2_stream`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0.
- R2: Each output value equals the largest of the four input samples at rows 2i and 2i+1 and columns 2j and 2j+1.
- R3: `out_valid` is high in exactly one cycle: the cycle right after a sample at an odd row and an odd column is accepted. It is never high in two consecutive cycles.
- R4: A complete frame produces exactly (IMG_W/2)*(IMG_H/2) outputs, in row-major pooled order.
- R5: Samples are compared as two's-complement signed values, so a block made only of negative numbers yields its least negative member.
- R6: A cycle with `in_valid` low does not advance the position, does not alter stored data, and gives `out_valid` low in the next cycle.
- R7: A sample accepted with `frame_start` high is taken as row 0, column 0, whatever part-frame came before it.
- R8: The sample at an even row and even column overwrites the stored entry, so values left from an earlier frame or row pair never reach an output.
- R9: After the last pixel of a frame, the next sample is taken as row 0, column 0 even without `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | Restart position tracking at the origin |
| in_valid | input | 1 | Input sample present |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Pooled result present |
| out_data | output | DATA_W | Signed pooled result |

## Verification
A wrong position counter, for example a missed column wrap or a row parity fault, shows at the ports at once. Outputs would appear on the wrong cycles, and the per-frame output count would drift, within the first row pair. A wrong storage update, such as a missed overwrite, an unsigned compare or a wrong slot index, shows in the value of the very next pooled output for the affected column. A missed overwrite only becomes visible when the earlier content is larger than the new block, so the stimulus puts large frames before small ones and uses all-negative data.

// File: rtl/pool_pkg.sv
package pool_pkg;
    // Action applied to the row store for the current sample
    typedef enum logic [1:0] {
        STEP_LOAD  = 2'd0,   // upper row, even column: overwrite
        STEP_MERGE = 2'd1,   // keep running maximum
        STEP_EMIT  = 2'd2    // lower row, odd column: maximum and output
    } step_e;
endpackage

// File: rtl/pool_scan_ctrl.sv
module pool_scan_ctrl
    import pool_pkg::*;
#(
    parameter int IMG_W = 8,
    parameter int IMG_H = 6,
    localparam int COL_W = $clog2(IMG_W),
    localparam int ROW_W = $clog2(IMG_H)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             in_valid,
    output logic [COL_W-1:0] cur_col,
    output step_e            cur_step
);
    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
    } pos_t;

    pos_t pos_d, pos_q;
    logic [ROW_W-1:0] cur_row;

    always_comb begin
        cur_col = frame_start ? '0 : pos_q.col;
        cur_row = frame_start ? '0 : pos_q.row;

        if (!cur_row[0] && !cur_col[0])      cur_step = STEP_LOAD;
        else if (cur_row[0] && cur_col[0])   cur_step = STEP_EMIT;
        else                                 cur_step = STEP_MERGE;

        pos_d.col = cur_col;
        pos_d.row = cur_row;
        if (in_valid) begin
            if (cur_col == COL_W'(IMG_W - 1)) begin
                pos_d.col = '0;
                pos_d.row = (cur_row == ROW_W'(IMG_H - 1)) ? '0 : cur_row + 1'b1;
            end else begin
                pos_d.col = cur_col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end
endmodule

// File: rtl/pool_line_mem.sv
module pool_line_mem #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [IDX_W-1:0]         idx,
    output logic signed [DATA_W-1:0] rd_data,
    input  logic                     wr_en,
    input  logic signed [DATA_W-1:0] wr_data
);
    logic signed [DATA_W-1:0] slot_q [DEPTH];

    assign rd_data = slot_q[idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (wr_en) begin
            slot_q[idx] <= wr_data;
        end
    end
endmodule

// File: rtl/pool_cmp.sv
module pool_cmp #(
    parameter int DATA_W = 16
) (
    input  logic signed [DATA_W-1:0] a,
    input  logic signed [DATA_W-1:0] b,
    output logic signed [DATA_W-1:0] y
);
    assign y = (a > b) ? a : b;
endmodule

// File: rtl/maxpool2x2_stream.sv
module maxpool2x2_stream
    import pool_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IMG_W  = 8,
    parameter int IMG_H  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int POOL_W = IMG_W / 2;
    localparam int COL_W  = $clog2(IMG_W);
    localparam int SLOT_W = (POOL_W > 1) ? $clog2(POOL_W) : 1;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] val;
    } out_t;

    out_t out_d, out_q;

    logic [COL_W-1:0]         col;
    step_e                    step;
    logic [SLOT_W-1:0]        slot;
    logic signed [DATA_W-1:0] stored, sample, biggest, merged;

    pool_scan_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .in_valid    (in_valid),
        .cur_col     (col),
        .cur_step    (step)
    );

    pool_line_mem #(.DATA_W(DATA_W), .DEPTH(POOL_W)) u_row (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (slot),
        .rd_data (stored),
        .wr_en   (in_valid),
        .wr_data (merged)
    );

    pool_cmp #(.DATA_W(DATA_W)) u_cmp (
        .a (stored),
        .b (sample),
        .y (biggest)
    );

    always_comb begin
        sample    = $signed(in_data);
        slot      = SLOT_W'(col >> 1);
        merged    = (step == STEP_LOAD) ? sample : biggest;
        out_d.vld = in_valid && (step == STEP_EMIT);
        out_d.val = out_d.vld ? merged : out_q.val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid = out_q.vld;
    assign out_data  = out_q.val;
endmodule

// File: rtl/pool_checker.sv
module pool_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    always @(negedge clk) begin
        if (!rst_n) p_reset_quiet_r1: assert (!out_valid);
    end

    p_emit_needs_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    p_no_back_to_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_dominates_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!out_valid || ($signed(out_data) >= $signed($past(in_data)))));
endmodule

bind maxpool2x2_stream pool_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/maxpool2x2_stream_bench.sv
module maxpool2x2_stream_bench;
    localparam int DW = 16;
    localparam int W  = 8;
    localparam int H  = 6;
    localparam int NOUT = (W / 2) * (H / 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic out_valid;
    logic [DW-1:0] out_data;

    int vectors = 0;
    int errors = 0;
    int lcg = 12345;
    int img [H][W];

    always #5 clk = ~clk;

    maxpool2x2_stream #(.DATA_W(DW), .IMG_W(W), .IMG_H(H)) u_maxpool2x2_stream (
        .clk (clk), .rst_n (rst_n), .frame_start (frame_start),
        .in_valid (in_valid), .in_data (in_data),
        .out_valid (out_valid), .out_data (out_data)
    );

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int next_rand();
        lcg = lcg * 1103515245 + 12345;
        return ((lcg >>> 8) & 32'h7fff) - 16000;
    endfunction

    // mode 0 ramp, 1 all negative, 2 pseudo-random, 3 large constant, 4 small
    task automatic fill(input int mode);
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++)
                case (mode)
                    0: img[r][c] = r * W + c;
                    1: img[r][c] = -(100 + ((r * 7 + c * 13) % 50));
                    2: img[r][c] = next_rand();
                    3: img[r][c] = 1000;
                    default: img[r][c] = c - r;
                endcase
    endtask

    function automatic int block_max(input int r, input int c);
        int m = img[r][c];
        if (img[r-1][c-1] > m) m = img[r-1][c-1];
        if (img[r-1][c]   > m) m = img[r-1][c];
        if (img[r][c-1]   > m) m = img[r][c-1];
        return m;
    endfunction

    // Streams img; checks output timing (R3) and value (tag) after each sample
    task automatic stream(input int gap, input int stop_after, input bit sof,
                          input string tag);
        int n = 0;
        int outs = 0;
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                bit emit;
                if (stop_after >= 0 && n == stop_after) begin
                    in_valid = 1'b0;
                    return;
                end
                in_valid = 1'b1;
                in_data = DW'(img[r][c]);
                frame_start = sof && (n == 0);
                @(negedge clk);
                frame_start = 1'b0;
                in_valid = 1'b0;
                emit = r[0] && c[0];
                check("R3 out_valid", int'(out_valid), int'(emit));
                if (out_valid) outs++;
                if (emit) check(tag, int'($signed(out_data)), block_max(r, c));
                if (gap > 0 && (n % gap) == gap - 1) begin
                    @(negedge clk);
                    check("R6 idle cycle out_valid", int'(out_valid), 0);
                end
                n++;
            end
        end
        check("R4 outputs per frame", outs, NOUT);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", int'(out_valid), 0);
    endtask

    task automatic t_ramp();
        fill(0);
        stream(0, -1, 1'b1, "R2 ramp max");
    endtask

    task automatic t_negative();
        fill(1);
        stream(0, -1, 1'b1, "R5 signed max");
    endtask

    task automatic t_gaps();
        fill(2);
        stream(3, -1, 1'b1, "R6 data with gaps");
    endtask

    task automatic t_stale();
        fill(3);
        stream(0, -1, 1'b1, "R2 constant");
        fill(4);
        stream(0, -1, 1'b1, "R8 overwrite stale");
    endtask

    task automatic t_wrap();
        fill(2);
        stream(0, -1, 1'b1, "R2 random");
        fill(4);
        stream(0, -1, 1'b0, "R9 wrap without start");
    endtask

    task automatic t_restart();
        fill(3);
        stream(0, 21, 1'b1, "R7 partial");
        @(negedge clk);
        fill(1);
        stream(0, -1, 1'b1, "R7 restart mid-frame");
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_ramp();
        t_negative();
        t_gaps();
        t_stale();
        t_wrap();
        t_restart();
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule